// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block keeps the tap position of a 128-step digital potentiometer and turns it into a registered select vector with exactly one line high. An upstream bus engine sends single-cycle strobes. A recall strobe copies a position from the nonvolatile store. A load strobe writes a byte that arrived over the serial interface. A step strobe carries one data bit, and that bit moves the wiper one tap up or one tap down.

Stepping is bit-serial. Each clocked bit moves the wiper by one tap, and the value of the bit sets the direction. At either end of the range the wiper stops rather than wrapping round. The position can be read back at any time as a byte whose top bit is zero. Reset puts the wiper at mid-scale until the recall load arrives.

Top module: `wiper_pos_reg`

## Requirements
- R1: In the cycle after synchronous reset, `pos` is 64 (binary 1000000), `rd_byte` is 0x40 and only `tap_sel[64]` is high.
- R2: A load strobe stores bits 6..0 of `load_byte` and discards bit 7. The new value appears on `pos` after the next rising clock edge.
- R3: `rd_byte` always equals `pos` in bits 6..0, and bit 7 of `rd_byte` is always 0.
- R4: A step strobe with `step_bit` = 1 adds one to `pos`, and one with `step_bit` = 0 subtracts one. Each clock cycle with the strobe set makes one step.
- R5: Stepping saturates. A step up at 127 and a step down at 0 leave `pos` unchanged.
- R6: When no strobe is asserted, `pos` keeps its value, so the last stepped position stays after a step stream ends.
- R7: A recall strobe writes `recall_pos` into `pos` at the next rising clock edge.
- R8: When strobes arrive together, recall takes priority over load, and load takes priority over step.
- R9: `tap_sel` is one-hot. Its high bit is the value that `pos` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recall_en | input | 1 | Recall strobe from the nonvolatile store |
| recall_pos | input | 7 | Position to be recalled |
| load_en | input | 1 | Byte load strobe |
| load_byte | input | 8 | Byte written by the serial interface |
| step_en | input | 1 | Step strobe, one per data bit |
| step_bit | input | 1 | Step direction: 1 steps up, 0 steps down |
| pos | output | 7 | Current wiper position |
| rd_byte | output | 8 | Position as a byte, top bit zero |
| tap_sel | output | 128 | Registered one-hot tap select |

## Verification
The bench uses the default widths: a 7-bit position, an 8-bit byte and 128 taps. These are small enough to cover the whole space. The load test drives all 256 byte values, so every discarded top bit and every position is seen. The recall test writes every one of the 128 positions. Continuous step streams run the wiper from one end of the range to the other and then push past both limits. Combined strobes exercise each level of the priority order. On every cycle the bench checks `tap_sel` against the position it predicted for the cycle before.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_STEP   = 2'd1,
    SRC_LOAD   = 2'd2,
    SRC_RECALL = 2'd3
  } wpr_src_e;
endpackage

// File: rtl/wpr_src_arb.sv
module wpr_src_arb
  import wpr_pkg::*;
(
  input  logic     recall_en,
  input  logic     load_en,
  input  logic     step_en,
  output wpr_src_e src
);
  // Fixed priority: recall, then byte load, then step (R8)
  always_comb begin
    if (recall_en)    src = SRC_RECALL;
    else if (load_en) src = SRC_LOAD;
    else if (step_en) src = SRC_STEP;
    else              src = SRC_HOLD;
  end
endmodule

// File: rtl/wpr_sat_step.sv
module wpr_sat_step #(
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0] cur,
  input  logic             up,
  output logic [POS_W-1:0] nxt
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] BOT = '0;

  // Clamp at both ends rather than wrapping (R5)
  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
    else    nxt = (cur == BOT) ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/wpr_tap_decode.sv
module wpr_tap_decode #(
  parameter int POS_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [POS_W-1:0]         pos_in,
  output logic [(1<<POS_W)-1:0]    tap_q
);
  localparam int NTAPS = 1 << POS_W;
  localparam int MID   = 1 << (POS_W - 1);

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap_q[i] <= (i == MID);
      else     tap_q[i] <= (pos_in == POS_W'(i));
    end
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wpr_pkg::*;
#(
  parameter int POS_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      recall_en,
  input  logic [POS_W-1:0]          recall_pos,
  input  logic                      load_en,
  input  logic [BYTE_W-1:0]         load_byte,
  input  logic                      step_en,
  input  logic                      step_bit,
  output logic [POS_W-1:0]          pos,
  output logic [BYTE_W-1:0]         rd_byte,
  output logic [(1<<POS_W)-1:0]     tap_sel
);
  localparam int NTAPS = 1 << POS_W;
  localparam logic [POS_W-1:0] MID = POS_W'(NTAPS / 2);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
  localparam int PAD_W = BYTE_W - POS_W;

  wpr_src_e          src;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  stepped;

  wpr_src_arb u_arb (
    .recall_en (recall_en),
    .load_en   (load_en),
    .step_en   (step_en),
    .src       (src)
  );

  wpr_sat_step #(.POS_W(POS_W)) u_step (
    .cur (pos_q),
    .up  (step_bit),
    .nxt (stepped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= MID;
    end else begin
      unique case (src)
        SRC_RECALL: pos_q <= recall_pos;
        SRC_LOAD:   pos_q <= load_byte[POS_W-1:0];
        SRC_STEP:   pos_q <= stepped;
        default:    pos_q <= pos_q;
      endcase
    end
  end

  wpr_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .pos_in (pos_q),
    .tap_q  (tap_sel)
  );

  assign pos     = pos_q;
  assign rd_byte = {{PAD_W{1'b0}}, pos_q};

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!recall_en && !load_en && !step_en) |=> $stable(pos_q));
  assert_recall_R7: assert property (@(posedge clk) disable iff (rst)
    recall_en |=> pos_q == $past(recall_pos));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && !recall_en) |=> pos_q == $past(load_byte[POS_W-1:0]));
  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_bit && !load_en && !recall_en && pos_q != TOP)
      |=> pos_q == POS_W'($past(pos_q) + 1'b1));
  assert_sat_top_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_bit && !load_en && !recall_en && pos_q == TOP)
      |=> pos_q == TOP);
  assert_sat_bot_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_bit && !load_en && !recall_en && pos_q == '0)
      |=> pos_q == '0);
  assert_tap_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> tap_sel[$past(pos_q)]);
endmodule

// File: tb/wiper_pos_reg_tb_top.sv
module wiper_pos_reg_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         recall_en = 1'b0;
  logic [6:0]   recall_pos = '0;
  logic         load_en = 1'b0;
  logic [7:0]   load_byte = '0;
  logic         step_en = 1'b0;
  logic         step_bit = 1'b0;
  logic [6:0]   pos;
  logic [7:0]   rd_byte;
  logic [127:0] tap_sel;

  int compared = 0;
  int mismatched = 0;
  int exp_pos = 64;
  int prev_pos = 64;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_pos_reg dut_i (
    .clk(clk), .rst(rst),
    .recall_en(recall_en), .recall_pos(recall_pos),
    .load_en(load_en), .load_byte(load_byte),
    .step_en(step_en), .step_bit(step_bit),
    .pos(pos), .rd_byte(rd_byte), .tap_sel(tap_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_tap(input string tag, input int exp);
    logic [127:0] want;
    want = 128'd1 << exp;
    compared++;
    if (tap_sel !== want) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, tap_sel, want);
    end
  endtask

  // Called at a negedge: drive strobes, advance one cycle, check.
  task automatic cyc(input bit rc, input int rp, input bit ld, input int lb,
                     input bit st, input bit sb, input string tag);
    recall_en = rc; recall_pos = 7'(rp);
    load_en = ld; load_byte = 8'(lb);
    step_en = st; step_bit = sb;
    prev_pos = exp_pos;
    if (rc)      exp_pos = rp & 127;
    else if (ld) exp_pos = lb & 127;
    else if (st) exp_pos = sb ? ((exp_pos == 127) ? 127 : exp_pos + 1)
                              : ((exp_pos == 0) ? 0 : exp_pos - 1);
    @(negedge clk);
    chk(tag, int'(pos), exp_pos);
    chk({tag, " R3 rd_byte"}, int'(rd_byte), exp_pos);
    chk_tap({tag, " R9 tap lag"}, prev_pos);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 pos", int'(pos), 64);
    chk("R1 rd_byte", int'(rd_byte), 8'h40);
    chk_tap("R1 tap", 64);

    // R2/R3: every byte value, top bit discarded
    for (int b = 0; b < 256; b++) cyc(0, 0, 1, b, 0, 0, "R2 load");

    // R7: every recall value
    for (int p = 0; p < 128; p++) cyc(1, p, 0, 0, 0, 0, "R7 recall");

    // R4/R5: up-stream from 0 past the top
    cyc(1, 0, 0, 0, 0, 0, "R7 recall zero");
    for (int k = 0; k < 132; k++) cyc(0, 0, 0, 0, 1, 1, "R4 R5 step up");
    // R6: hold after stream ends
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, "R6 hold top");
    // down-stream past the bottom
    for (int k = 0; k < 132; k++) cyc(0, 0, 0, 0, 1, 0, "R4 R5 step down");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, "R6 hold bottom");
    // mixed direction stream
    cyc(0, 0, 1, 8'hA0, 0, 0, "R2 load mid");
    for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0, 1, k[0] | k[2], "R4 mixed step");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, "R6 hold mixed");

    // R8: priority
    cyc(1, 5, 1, 90, 1, 1, "R8 recall over load and step");
    cyc(0, 0, 1, 8'hF7, 1, 0, "R8 load over step");
    cyc(1, 100, 0, 0, 1, 0, "R8 recall over step");
    cyc(1, 17, 1, 33, 0, 0, "R8 recall over load");
    cyc(0, 0, 0, 0, 0, 0, "R6 idle");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule